// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors that index their tables in different ways. The global component combines the branch address with a shift register of recent outcomes from all branches. The local component first looks up the history of the branch itself in a per-address history table. It then uses that history, mixed with the address, to pick a counter in a second table. A third table of 2-bit chooser counters, indexed by the branch address alone, decides for each branch which component gives the final answer.

The fetch side presents an address on the predict port and reads back, in the same cycle, the final direction, both component directions and the chooser's pick. When the branch resolves, the back end presents the address, the real outcome and the two component directions that were saved at prediction time. On the next clock edge the block trains both components and, where the components disagreed, the chooser. History registers are updated only at resolution, so an index computed at update time matches the one used at prediction when no other update came between.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every predict address returns local-not-taken, global-not-taken, final not-taken and a chooser pick of local (predUseGlobal = 0).
- R2: predTaken equals predGlobal when predUseGlobal is 1 and equals predLocal when it is 0.
- R3: The global counter index is predPc[GHIST_W-1:0] XOR the global history. On each update the history shifts left by one bit and the outcome enters at bit 0.
- R4: The local history entry is selected by pc[LHT_IDX_W-1:0]. The local counter index is that entry XOR pc[LHIST_W-1:0]. On each update the selected entry shifts left by one bit and the outcome enters at bit 0.
- R5: The component counters saturate at 0 and at all-ones. A component predicts taken when the top bit of its counter is set. Global counters are GCTR_W bits wide (default 3) and reset to 3. Local counters are LCTR_W bits wide (default 2) and reset to 1.
- R6: The chooser entry stays unchanged on an update where updLocalPred equals updGlobalPred.
- R7: When the saved predictions disagree, the chooser entry steps by one toward the component whose prediction matched updTaken, saturating in 0..3. Values 2 and 3 pick global, 0 and 1 pick local.
- R8: Both component counters and both histories train on every update with updValid = 1, whatever the chooser picked. Nothing changes when updValid is 0.
- R9: The chooser table is indexed by pc[SEL_IDX_W-1:0], and its entries reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| predPc | input | PC_W | Branch address to predict |
| predTaken | output | 1 | Final predicted direction |
| predLocal | output | 1 | Local component direction |
| predGlobal | output | 1 | Global component direction |
| predUseGlobal | output | 1 | Chooser picks the global component |
| updValid | input | 1 | A resolved branch is presented |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome |
| updLocalPred | input | 1 | Local direction saved at prediction |
| updGlobalPred | input | 1 | Global direction saved at prediction |

## Verification
The hardest state to reach is the chooser of one address being walked to both saturation limits. This needs runs of updates on which the components disagree and a single side is right each time. Honest training seldom produces such runs, so directed phases supply saved predictions that disagree on purpose. Agreeing updates then show that the chooser holds. Long mixed runs follow, with loop-shaped, alternating and cross-correlated outcome streams over a few addresses, so that both histories and the counter tables see collisions and saturation. A behavioural model is compared against all four outputs on every clock.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;

  typedef struct packed {
    logic doUpdate;   // train components and histories
    logic outcome;    // resolved direction
    logic selWrite;   // chooser entry must move
    logic selUp;      // move toward global
  } tpStrobes_t;

  function automatic logic [7:0] satNext(input logic [7:0] value, input logic up,
                                         input logic [7:0] maxValue);
    if (up) return (value == maxValue) ? value : value + 8'd1;
    else    return (value == 8'd0) ? value : value - 8'd1;
  endfunction

endpackage

// File: rtl/tp_ctrl.sv
`timescale 1ns/1ps
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updLocalPred,
  input  logic       updGlobalPred,
  output tpStrobes_t strobes
);
  logic disagree;

  always_comb begin
    disagree         = updLocalPred ^ updGlobalPred;
    strobes.doUpdate = updValid;
    strobes.outcome  = updTaken;
    strobes.selWrite = updValid & disagree;
    strobes.selUp    = (updGlobalPred == updTaken);
  end
endmodule

// File: rtl/tp_datapath.sv
`timescale 1ns/1ps
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int GHIST_W   = 8,
  parameter int GCTR_W    = 3,
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 8,
  parameter int LCTR_W    = 2,
  parameter int SEL_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] predPc,
  input  logic [PC_W-1:0] updPc,
  input  tpStrobes_t      strobes,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  output logic            predUseGlobal
);
  localparam int G_N    = 1 << GHIST_W;
  localparam int LHT_N  = 1 << LHT_IDX_W;
  localparam int LP_N   = 1 << LHIST_W;
  localparam int SEL_N  = 1 << SEL_IDX_W;
  localparam int G_MAX  = (1 << GCTR_W) - 1;
  localparam int G_INIT = (1 << (GCTR_W - 1)) - 1;
  localparam int L_MAX  = (1 << LCTR_W) - 1;
  localparam int L_INIT = (1 << (LCTR_W - 1)) - 1;

  logic [GCTR_W-1:0]  gTable   [G_N];
  logic [LHIST_W-1:0] lhtTable [LHT_N];
  logic [LCTR_W-1:0]  lTable   [LP_N];
  logic [1:0]         selTable [SEL_N];
  logic [GHIST_W-1:0] gHist;

  // predict-side lookup
  logic [GHIST_W-1:0] gIdxP;
  logic [LHIST_W-1:0] lHistP, lIdxP;
  always_comb begin
    gIdxP         = predPc[GHIST_W-1:0] ^ gHist;
    lHistP        = lhtTable[predPc[LHT_IDX_W-1:0]];
    lIdxP         = lHistP ^ predPc[LHIST_W-1:0];
    predGlobal    = gTable[gIdxP][GCTR_W-1];
    predLocal     = lTable[lIdxP][LCTR_W-1];
    predUseGlobal = selTable[predPc[SEL_IDX_W-1:0]][1];
    predTaken     = predUseGlobal ? predGlobal : predLocal;
  end

  // update-side lookup and next values
  logic [GHIST_W-1:0]   gIdxU;
  logic [LHT_IDX_W-1:0] lhtIdxU;
  logic [LHIST_W-1:0]   lHistU, lIdxU;
  logic [SEL_IDX_W-1:0] selIdxU;
  logic [GCTR_W-1:0]    gNext;
  logic [LCTR_W-1:0]    lNext;
  logic [1:0]           selNext;
  always_comb begin
    gIdxU   = updPc[GHIST_W-1:0] ^ gHist;
    lhtIdxU = updPc[LHT_IDX_W-1:0];
    lHistU  = lhtTable[lhtIdxU];
    lIdxU   = lHistU ^ updPc[LHIST_W-1:0];
    selIdxU = updPc[SEL_IDX_W-1:0];
    gNext   = GCTR_W'(satNext(8'(gTable[gIdxU]), strobes.outcome, 8'(G_MAX)));
    lNext   = LCTR_W'(satNext(8'(lTable[lIdxU]), strobes.outcome, 8'(L_MAX)));
    selNext = 2'(satNext(8'(selTable[selIdxU]), strobes.selUp, 8'd3));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gHist <= '0;
      for (int i = 0; i < G_N; i++)   gTable[i]   <= GCTR_W'(G_INIT);
      for (int i = 0; i < LHT_N; i++) lhtTable[i] <= '0;
      for (int i = 0; i < LP_N; i++)  lTable[i]   <= LCTR_W'(L_INIT);
      for (int i = 0; i < SEL_N; i++) selTable[i] <= 2'd1;
    end else if (strobes.doUpdate) begin
      gTable[gIdxU]     <= gNext;
      lTable[lIdxU]     <= lNext;
      gHist             <= {gHist[GHIST_W-2:0], strobes.outcome};
      lhtTable[lhtIdxU] <= {lHistU[LHIST_W-2:0], strobes.outcome};
      if (strobes.selWrite) selTable[selIdxU] <= selNext;
    end
  end
endmodule

// File: rtl/tournament_predictor.sv
`timescale 1ns/1ps
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int GHIST_W   = 8,
  parameter int GCTR_W    = 3,
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 8,
  parameter int LCTR_W    = 2,
  parameter int SEL_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  output logic            predUseGlobal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updLocalPred,
  input  logic            updGlobalPred
);
  tpStrobes_t strobes;

  tp_ctrl u_ctrl (
    .updValid(updValid), .updTaken(updTaken),
    .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred),
    .strobes(strobes)
  );

  tp_datapath #(
    .PC_W(PC_W), .GHIST_W(GHIST_W), .GCTR_W(GCTR_W), .LHT_IDX_W(LHT_IDX_W),
    .LHIST_W(LHIST_W), .LCTR_W(LCTR_W), .SEL_IDX_W(SEL_IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .predPc(predPc), .updPc(updPc), .strobes(strobes),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal),
    .predUseGlobal(predUseGlobal)
  );
endmodule

// File: rtl/tp_checker.sv
`timescale 1ns/1ps
module tp_checker #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] predPc,
  input logic            predTaken,
  input logic            predLocal,
  input logic            predGlobal,
  input logic            predUseGlobal,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic            updLocalPred,
  input logic            updGlobalPred
);
  logic seenUpd;
  always_ff @(posedge clk) begin
    if (rst) seenUpd <= 1'b0;
    else if (updValid) seenUpd <= 1'b1;
  end

  // R1: untrained tables predict not-taken and pick local
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    !seenUpd |-> (!predTaken && !predUseGlobal && !predLocal && !predGlobal));

  // R2: when both components agree the final answer is that direction
  p_agree_final_r2: assert property (@(posedge clk) disable iff (rst)
    (predLocal == predGlobal) |-> (predTaken == predLocal));

  // R6: agreeing update leaves the chooser of the same address alone
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (updValid && updPc == predPc && updLocalPred == updGlobalPred)
      |=> (predPc != $past(predPc)) || $stable(predUseGlobal));

  // R7: global right on a disagreement never drops the global pick
  p_sel_to_global_r7: assert property (@(posedge clk) disable iff (rst)
    (updValid && updPc == predPc && updLocalPred != updGlobalPred &&
     updGlobalPred == updTaken && predUseGlobal)
      |=> (predPc != $past(predPc)) || predUseGlobal);

  // R7: local right on a disagreement never raises a local pick
  p_sel_to_local_r7: assert property (@(posedge clk) disable iff (rst)
    (updValid && updPc == predPc && updLocalPred != updGlobalPred &&
     updLocalPred == updTaken && !predUseGlobal)
      |=> (predPc != $past(predPc)) || !predUseGlobal);
endmodule

bind tournament_predictor tp_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .predPc(predPc), .predTaken(predTaken),
  .predLocal(predLocal), .predGlobal(predGlobal), .predUseGlobal(predUseGlobal),
  .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
  .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred)
);

// File: tb/tournament_predictor_tb.sv
`timescale 1ns/1ps
module tournament_predictor_tb;
  localparam int PC_W = 8, GHIST_W = 8, GCTR_W = 3, LHT_IDX_W = 6;
  localparam int LHIST_W = 8, LCTR_W = 2, SEL_IDX_W = 8;
  localparam int G_N = 1 << GHIST_W, LHT_N = 1 << LHT_IDX_W;
  localparam int LP_N = 1 << LHIST_W, SEL_N = 1 << SEL_IDX_W;

  logic clk = 1'b0;
  logic rst;
  logic [PC_W-1:0] predPc, updPc;
  logic predTaken, predLocal, predGlobal, predUseGlobal;
  logic updValid, updTaken, updLocalPred, updGlobalPred;

  always #10 clk = ~clk;

  tournament_predictor #(
    .PC_W(PC_W), .GHIST_W(GHIST_W), .GCTR_W(GCTR_W), .LHT_IDX_W(LHT_IDX_W),
    .LHIST_W(LHIST_W), .LCTR_W(LCTR_W), .SEL_IDX_W(SEL_IDX_W)
  ) u_dut (.*);

  int checks = 0, fails = 0;

  // behavioural model
  int gT[G_N], lT[LP_N], sT[SEL_N], lh[LHT_N];
  int gh;

  task automatic modelReset();
    gh = 0;
    foreach (gT[i]) gT[i] = (1 << (GCTR_W - 1)) - 1;
    foreach (lT[i]) lT[i] = (1 << (LCTR_W - 1)) - 1;
    foreach (sT[i]) sT[i] = 1;
    foreach (lh[i]) lh[i] = 0;
  endtask

  task automatic modelPred(input int pc, output bit l, output bit g, output bit u);
    int gi, li;
    gi = (pc ^ gh) % G_N;
    li = (lh[pc % LHT_N] ^ pc) % LP_N;
    g = gT[gi] >= (1 << (GCTR_W - 1));
    l = lT[li] >= (1 << (LCTR_W - 1));
    u = sT[pc % SEL_N] >= 2;
  endtask

  task automatic modelUpdate(input int pc, input bit t, input bit lp, input bit gp);
    int gi, li, si;
    gi = (pc ^ gh) % G_N;
    li = (lh[pc % LHT_N] ^ pc) % LP_N;
    si = pc % SEL_N;
    if (t) begin
      if (gT[gi] < (1 << GCTR_W) - 1) gT[gi]++;
      if (lT[li] < (1 << LCTR_W) - 1) lT[li]++;
    end else begin
      if (gT[gi] > 0) gT[gi]--;
      if (lT[li] > 0) lT[li]--;
    end
    if (lp != gp) begin
      if (gp == t) begin if (sT[si] < 3) sT[si]++; end
      else begin if (sT[si] > 0) sT[si]--; end
    end
    gh = ((gh << 1) | int'(t)) % G_N;
    lh[pc % LHT_N] = ((lh[pc % LHT_N] << 1) | int'(t)) % LP_N;
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    bit l, g, u;
    modelPred(int'(predPc), l, g, u);
    check({tag, " R4 R5 R8 local"}, predLocal, l);
    check({tag, " R3 R5 R8 global"}, predGlobal, g);
    check({tag, " R6 R7 R9 chooser"}, predUseGlobal, u);
    check({tag, " R2 final"}, predTaken, u ? g : l);
  endtask

  // one cycle: drive at negedge, compare, then commit model after the edge
  task automatic step(input string tag, input int ppc, input bit uv, input int upc,
                      input bit t, input bit lp, input bit gp);
    @(negedge clk);
    predPc = PC_W'(ppc); updValid = uv; updPc = PC_W'(upc);
    updTaken = t; updLocalPred = lp; updGlobalPred = gp;
    #1 compareAll(tag);
    @(posedge clk);
    if (uv) modelUpdate(upc, t, lp, gp);
  endtask

  // honest update: saved predictions come from the model
  task automatic honest(input string tag, input int ppc, input int upc, input bit t);
    bit l, g, u;
    modelPred(upc, l, g, u);
    step(tag, ppc, 1'b1, upc, t, l, g);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int loopCnt, lastA;
    rst = 1'b1; predPc = '0; updPc = '0;
    updValid = 1'b0; updTaken = 1'b0; updLocalPred = 1'b0; updGlobalPred = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state seen at several addresses
    for (int p = 0; p < 8; p++) step("R1", p * 37, 1'b0, 0, 1'b0, 1'b0, 1'b0);

    // R7: global right on disagreement, walk chooser of address 5 up and saturate
    for (int k = 0; k < 4; k++) step("R7 up", 5, 1'b1, 5, 1'b1, 1'b0, 1'b1);
    step("R7 sat-high", 5, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    // R6: agreeing updates keep the chooser
    for (int k = 0; k < 4; k++) step("R6 hold", 5, 1'b1, 5, k[0], k[0], k[0]);
    // R7: local right on disagreement, walk down past the floor
    for (int k = 0; k < 5; k++) step("R7 down", 5, 1'b1, 5, 1'b0, 1'b0, 1'b1);
    step("R7 sat-low", 5, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    // R8: updValid low changes nothing
    for (int k = 0; k < 4; k++) step("R8 idle", k * 3, 1'b0, k * 3, 1'b1, 1'b0, 1'b1);

    // R5: long taken run at one address saturates global counter
    for (int k = 0; k < 40; k++) honest("R5 sat", 9, 9, 1'b1);
    for (int k = 0; k < 20; k++) honest("R5 down", 9, 9, 1'b0);

    // mixed streams: loop-shaped, alternating, correlated
    loopCnt = 0; lastA = 0;
    for (int k = 0; k < 3000; k++) begin
      int sel, pc;
      bit t;
      sel = $urandom_range(0, 3);
      case (sel)
        0: begin pc = 8'h21; loopCnt = (loopCnt + 1) % 4; t = (loopCnt != 0); lastA = int'(t); end
        1: begin pc = 8'h62; t = k[0]; end
        2: begin pc = 8'hA3; t = bit'(lastA); end
        default: begin pc = $urandom_range(0, 255); t = bit'($urandom_range(0, 1)); end
      endcase
      if ($urandom_range(0, 9) == 0)
        step("R8 gap", $urandom_range(0, 255), 1'b0, pc, t, 1'b0, 1'b1);
      else if ($urandom_range(0, 7) == 0)
        step("R6 R7 forced", pc, 1'b1, pc, t, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      else
        honest("R3 R4 mix", (k % 3 == 0) ? $urandom_range(0, 255) : pc, pc, t);
    end

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule